// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block produces the winding commands for a two-phase bipolar stepper motor. It keeps a position in an eight-entry electrical cycle. It moves through that cycle each time the step input rises, and it turns the position into a polarity and an on/off command for each of the two phases. Those commands go to the two bridge current controllers that sit downstream.

One table serves all three drive styles. In half-step mode, each step moves one entry, so the motor alternates between one phase and two phases energised. In full-step mode, each step moves two entries, so the parity of the current position is kept. From an odd-numbered state the motor runs two phases on (normal drive). From an even-numbered state it runs one phase on (wave drive).

The step input is sampled in the system clock domain and edge-detected there. A level-sensitive active-low home input returns the cycle to state 1. An enable input blanks every drive command without disturbing the position.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position moves on a rising edge of `step_clk` only. It moves once per edge, and the update is visible one system clock after the edge is sampled. A step input held high causes no further movement.
- R2: With `half_mode` high, each step edge moves the position by exactly one state. The position wraps between state 8 and state 1 in both directions.
- R3: With `dir_cw` high, a step raises the state number. With `dir_cw` low, a step lowers it (modulo 8).
- R4: With `half_mode` low, each step edge moves the position by two states. The parity of the state number is kept, so odd states stay in two-phase-on drive and even states stay in one-phase-on drive.
- R5: While `home_n` is low, the position is forced to state 1 at the next system clock. This takes priority over a step edge in the same cycle.
- R6: While `enable` is low, `a_on`, `a_neg`, `b_on` and `b_neg` are all 0 in the same cycle. The position is kept and still follows step edges.
- R7: The drive outputs use this encoding: `x_on`=1 means the phase is energised, and `x_neg`=1 means negative polarity (`x_neg` is 0 when the phase is off). The states map as follows, written as (A,B): state 1 (+,+), state 2 (off,+), state 3 (−,+), state 4 (−,off), state 5 (−,−), state 6 (off,−), state 7 (+,−), state 8 (+,off).
- R8: A synchronous `rst` puts the position in state 1 and clears the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_clk | input | 1 | Step request; each rising edge is one step |
| dir_cw | input | 1 | 1 = clockwise (state number up), 0 = counterclockwise |
| half_mode | input | 1 | 1 = half-step, 0 = full-step |
| home_n | input | 1 | Active-low return to state 1 |
| enable | input | 1 | 0 switches off all drive outputs |
| a_on | output | 1 | Phase A energised |
| a_neg | output | 1 | Phase A negative polarity |
| b_on | output | 1 | Phase B energised |
| b_neg | output | 1 | Phase B negative polarity |

## Verification
The assertions assume that `step_clk`, `home_n`, `dir_cw` and `half_mode` are already synchronous to `clk`. They also assume that `step_clk` is low while `rst` is held, so that the first rising edge after reset is a true step. The bench meets both conditions by changing every input on the falling edge of `clk` and by keeping the step input low through reset. Every step pulse is held for at least one full clock, so each request is seen as exactly one edge.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int SEQ_LEN = 8;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef logic [IDX_W-1:0] seq_idx_t;

    typedef enum logic [1:0] {
        PH_OFF = 2'b00,
        PH_POS = 2'b01,
        PH_NEG = 2'b10
    } phase_cmd_t;

    typedef struct packed {
        phase_cmd_t a;
        phase_cmd_t b;
    } drive_t;

    // Index 0 is state 1 (home); odd state numbers drive both phases.
    function automatic drive_t drive_of(input seq_idx_t idx);
        drive_t d;
        case (idx)
            3'd0:    d = '{a: PH_POS, b: PH_POS};
            3'd1:    d = '{a: PH_OFF, b: PH_POS};
            3'd2:    d = '{a: PH_NEG, b: PH_POS};
            3'd3:    d = '{a: PH_NEG, b: PH_OFF};
            3'd4:    d = '{a: PH_NEG, b: PH_NEG};
            3'd5:    d = '{a: PH_OFF, b: PH_NEG};
            3'd6:    d = '{a: PH_POS, b: PH_NEG};
            default: d = '{a: PH_POS, b: PH_OFF};
        endcase
        return d;
    endfunction

    function automatic seq_idx_t step_size(input logic half);
        return half ? seq_idx_t'(1) : seq_idx_t'(2);
    endfunction

endpackage

// File: rtl/stepseq_edge.sv
module stepseq_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/stepseq_index.sv
module stepseq_index
    import stepseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     home_n,
    input  logic     advance,
    input  logic     dir_cw,
    input  logic     half_mode,
    output seq_idx_t idx
);
    seq_idx_t idx_q, delta;

    assign delta = step_size(half_mode);

    always_ff @(posedge clk) begin
        if (rst || !home_n)
            idx_q <= '0;
        else if (advance)
            idx_q <= dir_cw ? idx_q + delta : idx_q - delta;
    end

    assign idx = idx_q;
endmodule

// File: rtl/stepseq_drive_out.sv
module stepseq_drive_out
    import stepseq_pkg::*;
(
    input  seq_idx_t idx,
    input  logic     enable,
    output logic     a_on,
    output logic     a_neg,
    output logic     b_on,
    output logic     b_neg
);
    drive_t cmd;

    always_comb begin
        cmd   = drive_of(idx);
        a_on  = enable && (cmd.a != PH_OFF);
        a_neg = enable && (cmd.a == PH_NEG);
        b_on  = enable && (cmd.b != PH_OFF);
        b_neg = enable && (cmd.b == PH_NEG);
    end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stepseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_clk,
    input  logic dir_cw,
    input  logic half_mode,
    input  logic home_n,
    input  logic enable,
    output logic a_on,
    output logic a_neg,
    output logic b_on,
    output logic b_neg
);
    logic     step_rise;
    seq_idx_t idx_q;

    stepseq_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (step_clk),
        .rise   (step_rise)
    );

    stepseq_index u_index (
        .clk       (clk),
        .rst       (rst),
        .home_n    (home_n),
        .advance   (step_rise),
        .dir_cw    (dir_cw),
        .half_mode (half_mode),
        .idx       (idx_q)
    );

    stepseq_drive_out u_out (
        .idx    (idx_q),
        .enable (enable),
        .a_on   (a_on),
        .a_neg  (a_neg),
        .b_on   (b_on),
        .b_neg  (b_neg)
    );
endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker
    import stepseq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     home_n,
    input logic     step_rise,
    input logic     dir_cw,
    input logic     half_mode,
    input logic     enable,
    input logic     a_on,
    input logic     a_neg,
    input logic     b_on,
    input logic     b_neg,
    input seq_idx_t idx
);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (home_n && !step_rise) |=> $stable(idx));

    p_half_cw_r2: assert property (@(posedge clk) disable iff (rst)
        (home_n && step_rise && half_mode && dir_cw) |=> idx == seq_idx_t'($past(idx) + 3'd1));

    p_half_ccw_r3: assert property (@(posedge clk) disable iff (rst)
        (home_n && step_rise && half_mode && !dir_cw) |=> idx == seq_idx_t'($past(idx) - 3'd1));

    p_full_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (home_n && step_rise && !half_mode) |=> (idx[0] == $past(idx[0])) && (idx != $past(idx)));

    p_home_r5: assert property (@(posedge clk) disable iff (rst)
        !home_n |=> idx == '0);

    p_enable_off_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !(a_on || a_neg || b_on || b_neg));

    p_two_on_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && !idx[0]) |-> (a_on && b_on));

    p_polarity_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!a_neg || a_on) && (!b_neg || b_on));
endmodule

bind stepper_phase_seq stepseq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .home_n    (home_n),
    .step_rise (step_rise),
    .dir_cw    (dir_cw),
    .half_mode (half_mode),
    .enable    (enable),
    .a_on      (a_on),
    .a_neg     (a_neg),
    .b_on      (b_on),
    .b_neg     (b_neg),
    .idx       (idx_q)
);

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
    logic clk = 1'b0;
    logic rst, step_clk, dir_cw, half_mode, home_n, enable;
    logic a_on, a_neg, b_on, b_neg;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    stepper_phase_seq u_dut (
        .clk(clk), .rst(rst), .step_clk(step_clk), .dir_cw(dir_cw),
        .half_mode(half_mode), .home_n(home_n), .enable(enable),
        .a_on(a_on), .a_neg(a_neg), .b_on(b_on), .b_neg(b_neg)
    );

    // Entry: {dir_cw, half_mode, expected state index (state number - 1)}
    localparam int NV = 18;
    localparam logic [4:0] VEC [NV] = '{
        {1'b1,1'b1,3'd1}, {1'b1,1'b1,3'd2}, {1'b1,1'b1,3'd3}, {1'b0,1'b1,3'd2},
        {1'b1,1'b0,3'd4}, {1'b1,1'b0,3'd6}, {1'b1,1'b0,3'd0}, {1'b0,1'b0,3'd6},
        {1'b1,1'b1,3'd7}, {1'b1,1'b0,3'd1}, {1'b1,1'b0,3'd3}, {1'b0,1'b0,3'd1},
        {1'b0,1'b0,3'd7}, {1'b0,1'b1,3'd6}, {1'b1,1'b1,3'd7}, {1'b1,1'b1,3'd0},
        {1'b0,1'b1,3'd7}, {1'b0,1'b1,3'd6}
    };

    // {a_on, a_neg, b_on, b_neg} from the R7 table
    function automatic logic [3:0] expect_drive(input logic [2:0] idx);
        case (idx)
            3'd0: return 4'b1010;
            3'd1: return 4'b0010;
            3'd2: return 4'b1110;
            3'd3: return 4'b1100;
            3'd4: return 4'b1111;
            3'd5: return 4'b0011;
            3'd6: return 4'b1011;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {a_on, a_neg, b_on, b_neg};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse(input logic dir, input logic half);
        @(negedge clk);
        dir_cw = dir; half_mode = half; step_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic release_step();
        step_clk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_clk = 1'b0; dir_cw = 1'b1; half_mode = 1'b1;
        home_n = 1'b1; enable = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset state", expect_drive(3'd0));

        // R2 R3 R4 R7: table walk
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][4], VEC[i][3]);
            check("R2/R3/R4/R7 step", expect_drive(VEC[i][2:0]));
            release_step();
        end

        // R1: held-high step input moves once only (state 7 -> 8)
        pulse(1'b1, 1'b1);
        repeat (5) @(negedge clk);
        check("R1 held step", expect_drive(3'd7));
        release_step();

        // R5: home beats a coincident step edge
        @(negedge clk);
        dir_cw = 1'b1; half_mode = 1'b1; step_clk = 1'b1; home_n = 1'b0;
        @(negedge clk);
        check("R5 home priority", expect_drive(3'd0));
        home_n = 1'b1;
        release_step();
        check("R5 home held", expect_drive(3'd0));

        // R6: outputs off while disabled, position still tracks steps
        enable = 1'b0;
        #1;
        check("R6 disabled outputs", 4'b0000);
        pulse(1'b1, 1'b0);
        check("R6 disabled after step", 4'b0000);
        release_step();
        enable = 1'b1;
        #1;
        check("R6 re-enabled position", expect_drive(3'd2));

        // R8: synchronous reset mid-run
        pulse(1'b1, 1'b1);
        release_step();
        check("R3 before reset", expect_drive(3'd3));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 mid-run reset", expect_drive(3'd0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule